// File: doc/BRIEF.md
# HMAC-SHA256 Key and Pass Sequencer

This block turns an external SHA-256 compression engine into a keyed HMAC-SHA256 unit. The 256-bit key can come from three places: eight words written by the CPU, eight words fetched one at a time from a programmed memory address, or a dedicated key port whose words are XORed with a programmable 32-bit mask. In HMAC mode the block runs an inner pass and then an outer pass. The inner pass hashes the padded key XORed with 0x36 and then the message blocks. The outer pass hashes the padded key XORed with 0x5C and then a closing block that carries the inner digest. In plain SHA mode the key phases are skipped and the message blocks go straight to the engine.

Software raises the enable and holds it for the whole operation. In HMAC mode it then requests the key load and writes each 512-bit message block as sixteen 32-bit words. Before the final block it raises the last-block control. A done flag, cleared by writing 1, tells software when the next block may be written and when the result is ready. Separate status flags report that the key has been loaded, that a SHA result is ready, and that an HMAC result is ready.

Top module: `hmac_pass_seq`

## Requirements
- R1: After reset, stat_key_valid, stat_hash_ready, stat_hmac_ready, irq_flag, irq, core_start, kf_req and msg_ready are all 0.
- R2: With cfg_key_src=0 (CPU source), a pulse on ctl_key_go in HMAC mode latches the eight words written through key_wr_idx/key_wr_data. Word index 0 forms key bits [255:224] and index 7 forms bits [31:0]. stat_key_valid then rises.
- R3: With cfg_key_src=1 (memory source), exactly eight fetch requests are issued per key load. Request i has kf_addr = key_base_addr + 4*i. kf_req and kf_addr hold until kf_rvalid, and the data returned for request i becomes key word i.
- R4: With cfg_key_src=2 (key port), key word i is kp_key[255-32*i -: 32] XOR kp_mask.
- R5: With cfg_key_src=3 (reserved), ctl_key_go has no effect: stat_key_valid stays 0, no core request is issued and msg_ready stays 0.
- R6: In HMAC mode (cfg_sha_mode=0) the first core request is the inner block. This block is the key in bits [511:256], zeros in bits [255:0], XORed with the byte 0x36 in every byte, and it has core_init=1. Each following message block is sent with core_init=0, and the first word written lands in bits [511:480].
- R7: After the final message block in HMAC mode, the block sends the outer key block (same layout as R6 with byte 0x5C, core_init=1). It then sends a closing block made of the inner digest in [511:256], bit 255 set, zeros below, and 768 in bits [63:0], with core_init=0. The digest of that closing block appears on result when stat_hmac_ready rises, while stat_hash_ready stays 0.
- R8: In SHA mode (cfg_sha_mode=1) no key load takes place. The first message block has core_init=1 and later blocks have core_init=0. After the last block, result holds its digest and only stat_hash_ready is set.
- R9: irq_flag is set when a non-final message block completes and when a result becomes ready. It is cleared by a pulse on irq_clear. irq equals irq_flag AND irq_enable.
- R10: While irq_flag is 1, msg_ready is 0 and words presented on msg_valid/msg_data are discarded.
- R11: Dropping ctl_enable clears stat_key_valid, stat_hash_ready and stat_hmac_ready on the next clock and returns the block to idle.
- R12: At most one core request is outstanding: core_start is not raised again before core_done answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sha_mode | input | 1 | 0 selects HMAC, 1 selects plain SHA-256 |
| cfg_key_src | input | 2 | Key source: 0 CPU, 1 memory fetch, 2 key port, 3 reserved |
| ctl_enable | input | 1 | Held high for the whole operation |
| ctl_key_go | input | 1 | Pulse that requests a key load; stays pending until the key is valid |
| ctl_last_blk | input | 1 | Pulse that marks the next completing block as the last one |
| irq_enable | input | 1 | Interrupt enable |
| irq_clear | input | 1 | Write-1 clear of the done flag |
| key_wr_en | input | 1 | CPU key word write strobe |
| key_wr_idx | input | 3 | CPU key word index |
| key_wr_data | input | 32 | CPU key word data |
| kp_key | input | 256 | Key port value |
| kp_mask | input | 32 | Mask XORed into each key port word |
| key_base_addr | input | 32 | Memory address of key word 0 |
| kf_req | output | 1 | Key fetch request |
| kf_addr | output | 32 | Key fetch address |
| kf_rvalid | input | 1 | Key fetch response valid |
| kf_rdata | input | 32 | Key fetch response data |
| msg_valid | input | 1 | Message word strobe |
| msg_data | input | 32 | Message word |
| msg_ready | output | 1 | A message word is accepted this cycle if msg_valid is high |
| core_start | output | 1 | One-cycle request to compress core_block |
| core_init | output | 1 | 1: start from the standard initial hash; 0: chain from the previous state |
| core_block | output | 512 | Block to compress, valid while core_start is high |
| core_done | input | 1 | Engine finished the request |
| core_digest | input | 256 | Engine digest, valid with core_done |
| stat_key_valid | output | 1 | Key has been loaded |
| stat_hash_ready | output | 1 | SHA result ready |
| stat_hmac_ready | output | 1 | HMAC result ready |
| irq_flag | output | 1 | Done flag |
| irq | output | 1 | Interrupt line |
| result | output | 256 | Final digest |

## Verification
A wrong key word, a mis-chosen pad byte or a wrong word order shows up on core_block during the very cycle the affected request is issued. The bench compares every request against its own queue of expected blocks. A broken pass sequencer gives a request with the wrong core_init, an extra or missing request, or a ready flag of the wrong kind. These appear within one engine latency of the block at fault. Errors in the done flag or in message gating surface as a corrupted next message block, or as irq disagreeing with the flag on the same clock.

// File: rtl/hmac_seq_pkg.sv
package hmac_seq_pkg;
  localparam int WORD_W    = 32;
  localparam int KEY_WORDS = 8;
  localparam int BLK_WORDS = 16;
  localparam int KEY_W     = WORD_W * KEY_WORDS;
  localparam int DIG_W     = KEY_W;
  localparam int BLK_W     = WORD_W * BLK_WORDS;
  localparam int LEN_W     = 64;
  localparam logic [7:0] INNER_PAD = 8'h36;
  localparam logic [7:0] OUTER_PAD = 8'h5C;

  typedef enum logic [1:0] {
    KSRC_CPU  = 2'd0,
    KSRC_MEM  = 2'd1,
    KSRC_PORT = 2'd2,
    KSRC_RSVD = 2'd3
  } ksrc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_KEY, S_KLOAD, S_IPAD, S_IPADW, S_MSG, S_MSGW,
    S_OPAD, S_OPADW, S_TAIL, S_TAILW, S_DONE
  } seq_state_e;

  // Key zero-extended to a full block, every byte XORed with pad.
  function automatic logic [BLK_W-1:0] pad_key(input logic [KEY_W-1:0] k,
                                               input logic [7:0] pad);
    logic [BLK_W-1:0] b;
    b = {k, {(BLK_W-KEY_W){1'b0}}};
    return b ^ {(BLK_W/8){pad}};
  endfunction

  // Closing block of the outer pass: digest, marker bit, zeros, bit length.
  function automatic logic [BLK_W-1:0] outer_tail(input logic [DIG_W-1:0] d);
    logic [LEN_W-1:0] len;
    len = LEN_W'(BLK_W + DIG_W);
    return {d, 1'b1, {(BLK_W-DIG_W-1-LEN_W){1'b0}}, len};
  endfunction

  function automatic logic [31:0] word_addr(input logic [31:0] base,
                                            input int unsigned idx);
    return base + 32'(idx * (WORD_W/8));
  endfunction
endpackage

// File: rtl/hmac_key_loader.sv
module hmac_key_loader
  import hmac_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int KIDX_W = $clog2(KEY_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [1:0]        src,
  input  logic              cpu_we,
  input  logic [KIDX_W-1:0] cpu_idx,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic [KEY_W-1:0]  port_key,
  input  logic [WORD_W-1:0] port_mask,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_rvalid,
  input  logic [WORD_W-1:0] fetch_rdata,
  output logic [KEY_W-1:0]  key,
  output logic              done
);
  logic [WORD_W-1:0] cpu_w [KEY_WORDS];
  logic [WORD_W-1:0] key_w [KEY_WORDS];
  logic              fetching;
  logic [KIDX_W-1:0] idx;
  logic              fetch_last;

  assign fetch_last = (idx == KIDX_W'(KEY_WORDS-1));
  assign fetch_req  = fetching;
  assign fetch_addr = ADDR_W'(word_addr(32'(base_addr), int'(idx)));

  generate
    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_pack
      assign key[KEY_W-1-g*WORD_W -: WORD_W] = key_w[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEY_WORDS; i++) cpu_w[i] <= '0;
    end else if (cpu_we) begin
      cpu_w[cpu_idx] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEY_WORDS; i++) key_w[i] <= '0;
      fetching <= 1'b0;
      idx      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        fetching <= 1'b0;
        idx      <= '0;
      end else if (start) begin
        unique case (src)
          KSRC_CPU: begin
            for (int i = 0; i < KEY_WORDS; i++) key_w[i] <= cpu_w[i];
            done <= 1'b1;
          end
          KSRC_PORT: begin
            for (int i = 0; i < KEY_WORDS; i++)
              key_w[i] <= port_key[KEY_W-1-i*WORD_W -: WORD_W] ^ port_mask;
            done <= 1'b1;
          end
          KSRC_MEM: begin
            fetching <= 1'b1;
            idx      <= '0;
          end
          default: ;
        endcase
      end else if (fetching && fetch_rvalid) begin
        key_w[idx] <= fetch_rdata;
        if (fetch_last) begin
          fetching <= 1'b0;
          done     <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hmac_msg_packer.sv
module hmac_msg_packer
  import hmac_seq_pkg::*;
#(
  localparam int CNT_W = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  output logic [BLK_W-1:0]  block,
  output logic              full
);
  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last = (cnt == CNT_W'(BLK_WORDS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      block <= '0;
      cnt   <= '0;
      full  <= 1'b0;
    end else begin
      full <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (accept) begin
        block <= {block[BLK_W-WORD_W-1:0], word};
        if (at_last) begin
          cnt  <= '0;
          full <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hmac_pass_ctrl.sv
module hmac_pass_ctrl
  import hmac_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sha_mode,
  input  logic [1:0]       key_src,
  input  logic             key_go,
  input  logic             last_blk,
  input  logic             irq_clear,
  input  logic             key_done,
  input  logic [KEY_W-1:0] key,
  input  logic             msg_full,
  input  logic [BLK_W-1:0] msg_block,
  input  logic             core_done,
  input  logic [DIG_W-1:0] core_digest,
  output logic             loader_start,
  output logic             msg_ready,
  output logic             core_start,
  output logic             core_init,
  output logic [BLK_W-1:0] core_block,
  output logic             key_valid,
  output logic             hash_ready,
  output logic             hmac_ready,
  output logic             irq_flag,
  output logic [DIG_W-1:0] result
);
  seq_state_e state, state_nx;
  logic key_go_pend, last_pend, first_blk;
  logic [DIG_W-1:0] inner_dig;

  // Named internal events
  logic msg_blk_done, tail_done, final_msg_done, done_evt, msg_issue;

  assign msg_blk_done   = core_done && (state == S_MSGW);
  assign tail_done      = core_done && (state == S_TAILW);
  assign final_msg_done = msg_blk_done && last_pend;
  assign done_evt       = (msg_blk_done && (sha_mode || !last_pend)) || tail_done;
  assign msg_issue      = (state == S_MSG) && msg_full;

  assign loader_start = (state == S_KEY) && key_go_pend && (key_src != KSRC_RSVD);
  assign msg_ready    = (state == S_MSG) && !irq_flag && !msg_full;
  assign core_start   = msg_issue || (state == S_IPAD) || (state == S_OPAD) ||
                        (state == S_TAIL);

  always_comb begin
    core_init  = 1'b0;
    core_block = msg_block;
    unique case (state)
      S_IPAD: begin core_init = 1'b1; core_block = pad_key(key, INNER_PAD); end
      S_OPAD: begin core_init = 1'b1; core_block = pad_key(key, OUTER_PAD); end
      S_TAIL: core_block = outer_tail(inner_dig);
      S_MSG:  core_init = first_blk;
      default: ;
    endcase
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  state_nx = sha_mode ? S_MSG : S_KEY;
      S_KEY:   if (loader_start) state_nx = S_KLOAD;
      S_KLOAD: if (key_done) state_nx = S_IPAD;
      S_IPAD:  state_nx = S_IPADW;
      S_IPADW: if (core_done) state_nx = S_MSG;
      S_MSG:   if (msg_issue) state_nx = S_MSGW;
      S_MSGW:  if (core_done)
                 state_nx = !last_pend ? S_MSG : (sha_mode ? S_DONE : S_OPAD);
      S_OPAD:  state_nx = S_OPADW;
      S_OPADW: if (core_done) state_nx = S_TAIL;
      S_TAIL:  state_nx = S_TAILW;
      S_TAILW: if (core_done) state_nx = S_DONE;
      default: state_nx = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
    end else if (done_evt) begin
      irq_flag <= 1'b1;
    end else if (irq_clear) begin
      irq_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      key_go_pend <= 1'b0;
      last_pend   <= 1'b0;
      first_blk   <= 1'b0;
      key_valid   <= 1'b0;
      hash_ready  <= 1'b0;
      hmac_ready  <= 1'b0;
      inner_dig   <= '0;
      result      <= '0;
    end else if (!en) begin
      state       <= S_IDLE;
      key_go_pend <= 1'b0;
      last_pend   <= 1'b0;
      first_blk   <= 1'b0;
      key_valid   <= 1'b0;
      hash_ready  <= 1'b0;
      hmac_ready  <= 1'b0;
    end else begin
      state <= state_nx;
      if (key_done)    key_go_pend <= 1'b0;
      else if (key_go) key_go_pend <= 1'b1;
      if (last_blk) last_pend <= 1'b1;
      if (state == S_IDLE)  first_blk <= sha_mode;
      else if (msg_issue)   first_blk <= 1'b0;
      if (key_done) key_valid <= 1'b1;
      if (final_msg_done) begin
        if (sha_mode) begin
          hash_ready <= 1'b1;
          result     <= core_digest;
        end else begin
          inner_dig <= core_digest;
        end
      end
      if (tail_done) begin
        hmac_ready <= 1'b1;
        result     <= core_digest;
      end
    end
  end
endmodule

// File: rtl/hmac_pass_seq.sv
module hmac_pass_seq
  import hmac_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int KIDX_W = $clog2(KEY_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sha_mode,
  input  logic [1:0]        cfg_key_src,
  input  logic              ctl_enable,
  input  logic              ctl_key_go,
  input  logic              ctl_last_blk,
  input  logic              irq_enable,
  input  logic              irq_clear,
  input  logic              key_wr_en,
  input  logic [KIDX_W-1:0] key_wr_idx,
  input  logic [WORD_W-1:0] key_wr_data,
  input  logic [KEY_W-1:0]  kp_key,
  input  logic [WORD_W-1:0] kp_mask,
  input  logic [ADDR_W-1:0] key_base_addr,
  output logic              kf_req,
  output logic [ADDR_W-1:0] kf_addr,
  input  logic              kf_rvalid,
  input  logic [WORD_W-1:0] kf_rdata,
  input  logic              msg_valid,
  input  logic [WORD_W-1:0] msg_data,
  output logic              msg_ready,
  output logic              core_start,
  output logic              core_init,
  output logic [BLK_W-1:0]  core_block,
  input  logic              core_done,
  input  logic [DIG_W-1:0]  core_digest,
  output logic              stat_key_valid,
  output logic              stat_hash_ready,
  output logic              stat_hmac_ready,
  output logic              irq_flag,
  output logic              irq,
  output logic [DIG_W-1:0]  result
);
  logic             loader_start, key_done, msg_full, msg_accept;
  logic [KEY_W-1:0] key;
  logic [BLK_W-1:0] msg_block;

  assign msg_accept = msg_valid && msg_ready;
  assign irq        = irq_flag && irq_enable;

  hmac_key_loader #(.ADDR_W(ADDR_W)) u_key (
    .clk(clk), .rst_n(rst_n), .clr(!ctl_enable), .start(loader_start),
    .src(cfg_key_src), .cpu_we(key_wr_en), .cpu_idx(key_wr_idx),
    .cpu_wdata(key_wr_data), .port_key(kp_key), .port_mask(kp_mask),
    .base_addr(key_base_addr), .fetch_req(kf_req), .fetch_addr(kf_addr),
    .fetch_rvalid(kf_rvalid), .fetch_rdata(kf_rdata), .key(key),
    .done(key_done)
  );

  hmac_msg_packer u_msg (
    .clk(clk), .rst_n(rst_n), .clr(!ctl_enable), .accept(msg_accept),
    .word(msg_data), .block(msg_block), .full(msg_full)
  );

  hmac_pass_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(ctl_enable), .sha_mode(cfg_sha_mode),
    .key_src(cfg_key_src), .key_go(ctl_key_go), .last_blk(ctl_last_blk),
    .irq_clear(irq_clear), .key_done(key_done), .key(key),
    .msg_full(msg_full), .msg_block(msg_block), .core_done(core_done),
    .core_digest(core_digest), .loader_start(loader_start),
    .msg_ready(msg_ready), .core_start(core_start), .core_init(core_init),
    .core_block(core_block), .key_valid(stat_key_valid),
    .hash_ready(stat_hash_ready), .hmac_ready(stat_hmac_ready),
    .irq_flag(irq_flag), .result(result)
  );
endmodule

// File: rtl/hmac_pass_seq_chk.sv
module hmac_pass_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_enable,
  input logic              core_start,
  input logic              core_done,
  input logic              kf_req,
  input logic              kf_rvalid,
  input logic [ADDR_W-1:0] kf_addr,
  input logic              irq_clear,
  input logic              irq_flag,
  input logic              msg_ready,
  input logic              stat_key_valid,
  input logic              stat_hash_ready,
  input logic              stat_hmac_ready
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (core_start) busy_q <= 1'b1;
    else if (core_done)  busy_q <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !busy_q); // R12

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kf_req && !kf_rvalid && ctl_enable) |=> (kf_req && $stable(kf_addr))); // R3

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> (!stat_key_valid && !stat_hash_ready && !stat_hmac_ready)); // R11

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_hash_ready && stat_hmac_ready)); // R8

  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !core_done) |=> !irq_flag); // R9

  AST_MSG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag |-> !msg_ready); // R10

  AST_KEY_BEFORE_HMAC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_hmac_ready) |-> stat_key_valid); // R7
endmodule

bind hmac_pass_seq hmac_pass_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .core_start(core_start),
  .core_done(core_done), .kf_req(kf_req), .kf_rvalid(kf_rvalid),
  .kf_addr(kf_addr), .irq_clear(irq_clear), .irq_flag(irq_flag),
  .msg_ready(msg_ready), .stat_key_valid(stat_key_valid),
  .stat_hash_ready(stat_hash_ready), .stat_hmac_ready(stat_hmac_ready)
);

// File: tb/sim_hmac_pass_seq.sv
module sim_hmac_pass_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CORE_LAT   = 4;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_sha_mode = 1'b0;
  logic [1:0] cfg_key_src = 2'd0;
  logic ctl_enable = 1'b0, ctl_key_go = 1'b0, ctl_last_blk = 1'b0;
  logic irq_enable = 1'b0, irq_clear = 1'b0;
  logic key_wr_en = 1'b0;
  logic [2:0] key_wr_idx = '0;
  logic [31:0] key_wr_data = '0;
  logic [255:0] kp_key = '0;
  logic [31:0] kp_mask = '0;
  logic [31:0] key_base_addr = '0;
  logic kf_req;
  logic [31:0] kf_addr;
  logic kf_rvalid = 1'b0;
  logic [31:0] kf_rdata = '0;
  logic msg_valid = 1'b0;
  logic [31:0] msg_data = '0;
  logic msg_ready, core_start, core_init;
  logic [511:0] core_block;
  logic core_done = 1'b0;
  logic [255:0] core_digest = '0;
  logic stat_key_valid, stat_hash_ready, stat_hmac_ready, irq_flag, irq;
  logic [255:0] result;

  hmac_pass_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0, n_req = 0, fetch_n = 0;
  logic [512:0] exp_q[$];
  string        tag_q[$];

  task automatic chk(input bit ok, input string req,
                     input logic [511:0] act, input logic [511:0] e);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, e);
    end
  endtask

  function automatic logic [255:0] dig_of(input int n);
    logic [255:0] d;
    for (int w = 0; w < 8; w++)
      d[255-32*w -: 32] = (32'h9E3779B9 * 32'(n + 1)) ^ 32'(w * 7);
    return d;
  endfunction

  function automatic logic [511:0] padded(input logic [255:0] k, input logic [7:0] p);
    logic [511:0] b;
    for (int i = 0; i < 64; i++)
      b[511-8*i -: 8] = ((i < 32) ? k[255-8*i -: 8] : 8'h00) ^ p;
    return b;
  endfunction

  function automatic logic [511:0] tail_of(input logic [255:0] d);
    logic [511:0] b;
    b = '0;
    b[511:256] = d;
    b[255] = 1'b1;
    b[63:0] = 64'd768;
    return b;
  endfunction

  function automatic logic [511:0] msg_of(input int seed);
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[511-32*i -: 32] = 32'h10000000 * 32'(seed) + 32'(i);
    return b;
  endfunction

  function automatic logic [31:0] mem_word(input int i);
    return 32'hF00D0000 + 32'(i * 32'h111);
  endfunction

  task automatic expect_blk(input logic init, input logic [511:0] b, input string t);
    exp_q.push_back({init, b});
    tag_q.push_back(t);
  endtask

  // Engine model: captures requests, answers after CORE_LAT cycles.
  initial begin
    int pend;
    pend = 0;
    forever begin
      @(negedge clk);
      core_done = 1'b0;
      if (rst_n && core_start) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12 unexpected core request", core_block, '0);
        end else begin
          logic [512:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({core_init, core_block} == e, t, {core_init, core_block}, e[511:0] | {e[512], 511'b0});
        end
        n_req++;
        pend = CORE_LAT;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          core_done   = 1'b1;
          core_digest = dig_of(n_req - 1);
        end
      end
    end
  end

  // Key memory model
  initial begin
    forever begin
      @(negedge clk);
      if (kf_rvalid) kf_rvalid = 1'b0;
      else if (rst_n && kf_req) begin
        chk(kf_addr == key_base_addr + 32'(4 * fetch_n), "R3 fetch address",
            512'(kf_addr), 512'(key_base_addr + 32'(4 * fetch_n)));
        kf_rdata  = mem_word(fetch_n);
        kf_rvalid = 1'b1;
        fetch_n++;
      end
    end
  end

  // Per-clock compare of the interrupt line
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) chk(irq == (irq_flag && irq_enable), "R9 irq line",
                     512'(irq), 512'(irq_flag && irq_enable));
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic pulse_go();
    @(negedge clk); ctl_key_go = 1'b1; @(negedge clk); ctl_key_go = 1'b0;
  endtask
  task automatic pulse_last();
    @(negedge clk); ctl_last_blk = 1'b1; @(negedge clk); ctl_last_blk = 1'b0;
  endtask
  task automatic pulse_clear();
    @(negedge clk); irq_clear = 1'b1; @(negedge clk); irq_clear = 1'b0;
  endtask
  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    while (!msg_ready) @(negedge clk);
    msg_valid = 1'b1; msg_data = w;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask
  task automatic send_block(input logic [511:0] b);
    for (int i = 0; i < 16; i++) push_word(b[511-32*i -: 32]);
  endtask
  task automatic finish_run(input string req);
    chk(exp_q.size() == 0, req, 512'(exp_q.size()), '0);
    @(negedge clk); ctl_enable = 1'b0;
    @(negedge clk); @(negedge clk);
    chk({stat_key_valid, stat_hash_ready, stat_hmac_ready} == 3'b000,
        "R11 flags after enable drop",
        512'({stat_key_valid, stat_hash_ready, stat_hmac_ready}), '0);
    pulse_clear();
  endtask

  initial begin
    logic [255:0] k;
    int n0;
    repeat (3) @(negedge clk);
    chk({stat_key_valid, stat_hash_ready, stat_hmac_ready, irq_flag, irq,
         core_start, kf_req, msg_ready} == 8'h00, "R1 reset state",
        512'({stat_key_valid, stat_hash_ready, stat_hmac_ready, irq_flag, irq,
              core_start, kf_req, msg_ready}), '0);
    rst_n = 1'b1;
    irq_enable = 1'b1;

    // HMAC with CPU key, two message blocks
    k = 256'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978_8796A5B4C3D2E1F0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      key_wr_en = 1'b1; key_wr_idx = 3'(i); key_wr_data = k[255-32*i -: 32];
    end
    @(negedge clk); key_wr_en = 1'b0;
    n0 = n_req;
    expect_blk(1'b1, padded(k, 8'h36), "R2 R6 inner key block (cpu)");
    expect_blk(1'b0, msg_of(1), "R6 message block 1");
    expect_blk(1'b0, msg_of(2), "R10 message block 2 after discarded words");
    expect_blk(1'b1, padded(k, 8'h5C), "R7 outer key block");
    expect_blk(1'b0, tail_of(dig_of(n0 + 2)), "R7 outer closing block");
    cfg_sha_mode = 1'b0; cfg_key_src = 2'd0;
    @(negedge clk); ctl_enable = 1'b1;
    pulse_go();
    while (!stat_key_valid) @(negedge clk);
    chk(stat_key_valid, "R2 key valid", 512'(stat_key_valid), 512'(1));
    send_block(msg_of(1));
    while (!irq_flag) @(negedge clk);
    chk(irq && !msg_ready, "R9 R10 done flag after block",
        512'({irq, msg_ready}), 512'(2'b10));
    msg_valid = 1'b1; msg_data = 32'hDEADBEEF;
    @(negedge clk); @(negedge clk);
    msg_valid = 1'b0;
    pulse_clear();
    chk(!irq_flag, "R9 write-1 clear", 512'(irq_flag), '0);
    pulse_last();
    send_block(msg_of(2));
    while (!stat_hmac_ready) @(negedge clk);
    chk(result == dig_of(n0 + 4), "R7 hmac result", 512'(result), 512'(dig_of(n0 + 4)));
    chk(!stat_hash_ready && irq_flag, "R7 R9 only hmac ready, done set",
        512'({stat_hash_ready, irq_flag}), 512'(2'b01));
    finish_run("R7 all requests issued (cpu key)");

    // HMAC with key fetched from memory
    key_base_addr = 32'h1000_0010;
    for (int i = 0; i < 8; i++) k[255-32*i -: 32] = mem_word(i);
    fetch_n = 0;
    n0 = n_req;
    expect_blk(1'b1, padded(k, 8'h36), "R3 R6 inner key block (memory)");
    expect_blk(1'b0, msg_of(3), "R6 message block 3");
    expect_blk(1'b1, padded(k, 8'h5C), "R3 R7 outer key block (memory)");
    expect_blk(1'b0, tail_of(dig_of(n0 + 1)), "R7 outer closing block (memory)");
    cfg_key_src = 2'd1;
    @(negedge clk); ctl_enable = 1'b1;
    pulse_go();
    pulse_last();
    send_block(msg_of(3));
    while (!stat_hmac_ready) @(negedge clk);
    chk(fetch_n == 8, "R3 eight fetch requests", 512'(fetch_n), 512'(8));
    chk(result == dig_of(n0 + 3), "R7 hmac result (memory)",
        512'(result), 512'(dig_of(n0 + 3)));
    finish_run("R3 all requests issued (memory key)");

    // HMAC with masked key port
    kp_key  = 256'hA1A2A3A4_B1B2B3B4_C1C2C3C4_D1D2D3D4_E1E2E3E4_F1F2F3F4_01020304_11121314;
    kp_mask = 32'h5A5AA5A5;
    for (int i = 0; i < 8; i++) k[255-32*i -: 32] = kp_key[255-32*i -: 32] ^ kp_mask;
    n0 = n_req;
    expect_blk(1'b1, padded(k, 8'h36), "R4 inner key block (key port)");
    expect_blk(1'b0, msg_of(4), "R6 message block 4");
    expect_blk(1'b1, padded(k, 8'h5C), "R4 outer key block (key port)");
    expect_blk(1'b0, tail_of(dig_of(n0 + 1)), "R7 outer closing block (key port)");
    cfg_key_src = 2'd2;
    @(negedge clk); ctl_enable = 1'b1;
    pulse_go();
    pulse_last();
    send_block(msg_of(4));
    while (!stat_hmac_ready) @(negedge clk);
    chk(result == dig_of(n0 + 3), "R4 hmac result (key port)",
        512'(result), 512'(dig_of(n0 + 3)));
    finish_run("R4 all requests issued (key port)");

    // Plain SHA, two blocks
    n0 = n_req;
    expect_blk(1'b1, msg_of(5), "R8 first sha block starts from initial hash");
    expect_blk(1'b0, msg_of(6), "R8 second sha block chains");
    cfg_sha_mode = 1'b1;
    @(negedge clk); ctl_enable = 1'b1;
    send_block(msg_of(5));
    while (!irq_flag) @(negedge clk);
    pulse_clear();
    pulse_last();
    send_block(msg_of(6));
    while (!stat_hash_ready) @(negedge clk);
    chk(result == dig_of(n0 + 1), "R8 sha result", 512'(result), 512'(dig_of(n0 + 1)));
    chk(!stat_hmac_ready && !stat_key_valid, "R8 only hash ready, no key",
        512'({stat_hmac_ready, stat_key_valid}), '0);
    finish_run("R8 all requests issued (sha)");

    // Reserved key source
    n0 = n_req;
    cfg_sha_mode = 1'b0; cfg_key_src = 2'd3;
    @(negedge clk); ctl_enable = 1'b1;
    pulse_go();
    repeat (30) @(negedge clk);
    chk(!stat_key_valid && !msg_ready && !kf_req, "R5 reserved source ignored",
        512'({stat_key_valid, msg_ready, kf_req}), '0);
    chk(n_req == n0, "R5 no core request", 512'(n_req), 512'(n0));
    @(negedge clk); ctl_enable = 1'b0;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule